// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the single completion that answers one outstanding configuration request and turns it into a result. The request side pulses `req_start` when the request has finished transmission. It also states on `req_is_write` whether the request was a write. From then on the block watches a stream of 64-bit beats. Each beat carries start-of-packet and end-of-packet flags. The block takes the completion status from the header beat. It takes the returned dword from the end beat. It then reports one result on a single-cycle strobe.

A result is either success or device-not-found. Success with a read also returns the data. Device-not-found is reported for a non-zero completion status, and also when no end beat arrives within a fixed budget of clock cycles. Once a result has been given, the block goes idle and ignores the stream until the next request.

Top module: `cfg_cpl_receiver`

## Requirements
- R1: After reset, `res_valid` is 0, `res_code` is 0 and `res_data` is 0.
- R2: While no request is outstanding, no beat causes a result strobe, even one carrying both flags.
- R3: On an accepted start beat, the completion status is read from bits [46:44] of `beat_data`, which are bits [14:12] of the upper word. If that status is non-zero, the result at the end beat has `res_code` = 1 (device-not-found).
- R4: For a read with a zero status, the end beat produces `res_code` = 0 (success) and `res_data` = `beat_data[31:0]` of that end beat.
- R5: A beat with neither flag that arrives before any start beat of the current completion is dropped and produces no result. After a start beat, flagless beats are accepted but produce no result.
- R6: The wait budget is `TIMEOUT_CYC` clock cycles. If `req_start` is sampled at clock edge 0, beats sampled at edges 1 to `TIMEOUT_CYC` are considered. If none of them is an end beat, `res_valid` rises after edge `TIMEOUT_CYC` with `res_code` = 1. An end beat at edge `TIMEOUT_CYC` is still taken.
- R7: For a write request, the beat data is ignored. `res_data` stays 0 and only the status decides `res_code`.
- R8: `res_valid` is high for exactly one cycle, in the cycle after the deciding edge. After that the block is idle, and further beats give no result.
- R9: `res_data` and `res_code` hold their values until the next `req_start`. `req_start` clears both to 0.
- R10: A beat with both flags set is a complete completion. Its own status field decides the result, and for a read its low word is the data.
- R11: An end beat with no start beat before it in the current completion is judged with a status of zero.
- R12: A `req_start` while a request is outstanding abandons that request and restarts the wait budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Pulse: the request has finished transmission and the wait begins |
| req_is_write | input | 1 | Sampled with `req_start`: 1 for a write request |
| beat_valid | input | 1 | A completion beat is present |
| beat_sop | input | 1 | Start-of-packet flag of the beat |
| beat_eop | input | 1 | End-of-packet flag of the beat |
| beat_data | input | 64 | Beat contents: low word is data, upper word carries the status field |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 1 | 0 = success, 1 = device-not-found |
| res_data | output | 32 | Read data returned with a successful read |

## Verification
The assertions assume that `req_start` is a single-cycle pulse. They also assume that `beat_valid` is low whenever no beat is meant, so the flags are only acted on together with it. The bench drives every request as a one-cycle pulse. It changes inputs just after a rising edge and holds beats for exactly one cycle. It deliberately sends beats while idle and after a result, to show that they are dropped. The timeout window is checked with a small `TIMEOUT_CYC` value, so that the edge cases at the start and at the end of the window are both reached.

// File: rtl/cfg_cpl_pkg.sv
package cfg_cpl_pkg;
  localparam int BEAT_W   = 64;
  localparam int WORD_W   = 32;
  localparam int STAT_LSB = WORD_W + 12;
  localparam int STAT_W   = 3;

  typedef enum logic { RES_OK = 1'b0, RES_NODEV = 1'b1 } res_code_e;

  function automatic logic [STAT_W-1:0] cpl_status(input logic [BEAT_W-1:0] beat);
    return beat[STAT_LSB +: STAT_W];
  endfunction

  function automatic logic status_fails(input logic [STAT_W-1:0] st);
    return st != '0;
  endfunction

  function automatic logic [WORD_W-1:0] low_word(input logic [BEAT_W-1:0] beat);
    return beat[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/cpl_beat_filter.sv
module cpl_beat_filter
  import cfg_cpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              valid,
  input  logic              sop,
  input  logic              eop,
  input  logic [BEAT_W-1:0] beat,
  output logic              take,
  output logic              eop_take,
  output logic [STAT_W-1:0] status
);
  logic              seen_sop_q;
  logic [STAT_W-1:0] status_q;
  logic              sop_take;

  assign take     = enable && valid && (sop || eop || seen_sop_q);
  assign sop_take = take && sop;
  assign eop_take = take && eop;
  assign status   = sop_take ? cpl_status(beat) : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      seen_sop_q <= 1'b0;
      status_q   <= '0;
    end else if (eop_take) begin
      seen_sop_q <= 1'b0;
      status_q   <= '0;
    end else if (sop_take) begin
      seen_sop_q <= 1'b1;
      status_q   <= cpl_status(beat);
    end
  end
endmodule

// File: rtl/cpl_wait_timer.sv
module cpl_wait_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = active && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (active && !expire) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_cpl_receiver.sv
module cfg_cpl_receiver
  import cfg_cpl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_is_write,
  input  logic              beat_valid,
  input  logic              beat_sop,
  input  logic              beat_eop,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              res_valid,
  output logic              res_code,
  output logic [WORD_W-1:0] res_data
);
  logic              busy_q;
  logic              is_wr_q;
  logic              beat_take;
  logic              eop_take;
  logic              wait_expire;
  logic [STAT_W-1:0] cur_status;
  logic              status_fail;
  logic              res_valid_q;
  res_code_e         res_code_q;
  logic [WORD_W-1:0] res_data_q;

  cpl_beat_filter u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (req_start),
    .enable   (busy_q),
    .valid    (beat_valid),
    .sop      (beat_sop),
    .eop      (beat_eop),
    .beat     (beat_data),
    .take     (beat_take),
    .eop_take (eop_take),
    .status   (cur_status)
  );

  cpl_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (req_start),
    .active  (busy_q),
    .expire  (wait_expire)
  );

  assign status_fail = status_fails(cur_status);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      is_wr_q     <= 1'b0;
      res_valid_q <= 1'b0;
      res_code_q  <= RES_OK;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (req_start) begin
        busy_q     <= 1'b1;
        is_wr_q    <= req_is_write;
        res_code_q <= RES_OK;
        res_data_q <= '0;
      end else if (busy_q) begin
        if (eop_take) begin
          busy_q      <= 1'b0;
          res_valid_q <= 1'b1;
          res_code_q  <= status_fail ? RES_NODEV : RES_OK;
          if (!status_fail && !is_wr_q) res_data_q <= low_word(beat_data);
        end else if (wait_expire) begin
          busy_q      <= 1'b0;
          res_valid_q <= 1'b1;
          res_code_q  <= RES_NODEV;
        end
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_code  = res_code_q;
  assign res_data  = res_data_q;
endmodule

// File: rtl/cfg_cpl_receiver_chk.sv
module cfg_cpl_receiver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic        busy_q,
  input logic        beat_take,
  input logic        eop_take,
  input logic        status_fail,
  input logic        wait_expire,
  input logic        res_valid,
  input logic        res_code,
  input logic [31:0] res_data
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !req_start) |=> !res_valid);

  assert_idle_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !beat_take);

  assert_bad_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_start && eop_take && status_fail) |=> (res_valid && res_code));

  assert_expire_nodev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_start && wait_expire && !eop_take) |=> (res_valid && res_code));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_start && !eop_take) |=> $stable(res_data));
endmodule

bind cfg_cpl_receiver cfg_cpl_receiver_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_start   (req_start),
  .busy_q      (busy_q),
  .beat_take   (beat_take),
  .eop_take    (eop_take),
  .status_fail (status_fail),
  .wait_expire (wait_expire),
  .res_valid   (res_valid),
  .res_code    (res_code),
  .res_data    (res_data)
);

// File: tb/tb_cfg_cpl_receiver.sv
`timescale 1ns/1ps
module tb_cfg_cpl_receiver;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_is_write = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_sop = 1'b0;
  logic        beat_eop = 1'b0;
  logic [63:0] beat_data = '0;
  logic        res_valid;
  logic        res_code;
  logic [31:0] res_data;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_cpl_receiver #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_is_write(req_is_write),
    .beat_valid(beat_valid), .beat_sop(beat_sop), .beat_eop(beat_eop),
    .beat_data(beat_data), .res_valid(res_valid), .res_code(res_code),
    .res_data(res_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] st, input logic [31:0] lo);
    logic [31:0] hi;
    hi = 32'h0A00_0004;
    hi[14:12] = st;
    return {hi, lo};
  endfunction

  task automatic request(input logic wr);
    req_start = 1'b1;
    req_is_write = wr;
    tick();
    req_start = 1'b0;
    req_is_write = 1'b0;
  endtask

  task automatic beat(input logic s, input logic e, input logic [63:0] d);
    beat_valid = 1'b1;
    beat_sop = s;
    beat_eop = e;
    beat_data = d;
    tick();
    beat_valid = 1'b0;
    beat_sop = 1'b0;
    beat_eop = 1'b0;
    beat_data = '0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(res_valid), 0);
    check("R1 code", 32'(res_code), 0);
    check("R1 data", res_data, 0);
  endtask

  task automatic t_idle();
    beat(1'b1, 1'b1, mk(3'd0, 32'h1111_2222));
    check("R2 idle beat", 32'(res_valid), 0);
    tick();
    check("R2 idle after", 32'(res_valid), 0);
    check("R2 data untouched", res_data, 0);
  endtask

  task automatic t_read_ok();
    request(1'b0);
    beat(1'b1, 1'b0, mk(3'd0, 32'h0));
    check("R5 mid no result", 32'(res_valid), 0);
    beat(1'b0, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'hDEAD_BEEF));
    check("R4 valid", 32'(res_valid), 1);
    check("R4 code", 32'(res_code), 0);
    check("R4 data", res_data, 32'hDEAD_BEEF);
    tick();
    check("R8 pulse ends", 32'(res_valid), 0);
    beat(1'b1, 1'b1, mk(3'd1, 32'h5555_5555));
    check("R8 idle after result", 32'(res_valid), 0);
    tick();
    check("R9 data held", res_data, 32'hDEAD_BEEF);
    check("R9 code held", 32'(res_code), 0);
    request(1'b0);
    check("R9 cleared by request", res_data, 0);
    tick();
  endtask

  task automatic t_bad_status();
    request(1'b0);
    beat(1'b1, 1'b0, mk(3'd2, 32'h0));
    beat(1'b0, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'hCAFE_0001));
    check("R3 valid", 32'(res_valid), 1);
    check("R3 nodev", 32'(res_code), 1);
    check("R3 no data", res_data, 0);
    tick();
  endtask

  task automatic t_drop();
    request(1'b0);
    beat(1'b0, 1'b0, mk(3'd7, 32'hFFFF_FFFF));
    check("R5 pre-sop dropped", 32'(res_valid), 0);
    beat(1'b1, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'h0BAD_F00D));
    check("R5 result code", 32'(res_code), 0);
    check("R5 result data", res_data, 32'h0BAD_F00D);
    tick();
  endtask

  task automatic t_single();
    request(1'b0);
    beat(1'b1, 1'b1, mk(3'd4, 32'h1234_5678));
    check("R10 single fail valid", 32'(res_valid), 1);
    check("R10 single fail code", 32'(res_code), 1);
    tick();
    request(1'b0);
    beat(1'b1, 1'b1, mk(3'd0, 32'h8765_4321));
    check("R10 single ok code", 32'(res_code), 0);
    check("R10 single ok data", res_data, 32'h8765_4321);
    tick();
  endtask

  task automatic t_no_sop();
    request(1'b0);
    beat(1'b0, 1'b1, mk(3'd5, 32'hA5A5_0000));
    check("R11 valid", 32'(res_valid), 1);
    check("R11 code", 32'(res_code), 0);
    check("R11 data", res_data, 32'hA5A5_0000);
    tick();
  endtask

  task automatic t_write();
    request(1'b1);
    beat(1'b1, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'h0000_1234));
    check("R7 write valid", 32'(res_valid), 1);
    check("R7 write code", 32'(res_code), 0);
    check("R7 write data ignored", res_data, 0);
    tick();
    request(1'b1);
    beat(1'b1, 1'b0, mk(3'd1, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'h0000_5678));
    check("R7 write fail code", 32'(res_code), 1);
    tick();
  endtask

  task automatic t_timeout();
    int early = 0;
    request(1'b0);
    for (int i = 1; i < TO; i++) begin
      tick();
      if (res_valid) early++;
    end
    check("R6 no early result", 32'(early), 0);
    tick();
    check("R6 timeout valid", 32'(res_valid), 1);
    check("R6 timeout code", 32'(res_code), 1);
    tick();
    request(1'b0);
    for (int i = 1; i < TO; i++) tick();
    beat(1'b0, 1'b1, mk(3'd0, 32'h7777_0001));
    check("R6 last-cycle eop code", 32'(res_code), 0);
    check("R6 last-cycle eop data", res_data, 32'h7777_0001);
    tick();
  endtask

  task automatic t_restart();
    int early = 0;
    request(1'b0);
    for (int i = 0; i < TO - 3; i++) tick();
    request(1'b0);
    for (int i = 1; i < TO; i++) begin
      tick();
      if (res_valid) early++;
    end
    check("R12 restart extends wait", 32'(early), 0);
    tick();
    check("R12 timeout after restart", 32'(res_valid), 1);
    tick();
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick();
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_read_ok();
    t_bad_status();
    t_drop();
    t_single();
    t_no_sop();
    t_write();
    t_timeout();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule